// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block forms products of two 16-bit signed fractional operands (Q15, range -1 to just below +1) and accumulates them into a 24-bit accumulator. Two operand registers, X and Y, feed a flow-through multiplier. Whenever either register is written, the product register P is recomputed on that same clock edge. No separate multiply command exists. P holds the 24 most significant bits of the fractional product.

A selectable shifter sits between P and the arithmetic unit. The arithmetic unit adds the shifted product into the accumulator, or subtracts it, and it can also load, add or subtract a 16-bit fractional operand, negate, or take the absolute value. A multiply-accumulate step takes one cycle: the accumulator takes in the P that was present before the edge, while a fresh X or Y write forms the next product on that same edge. Every operation updates the negative, overflow, zero and carry flags. A saturation control chooses between wrap-around and clamping on signed overflow.

All inputs are single-cycle strobes and levels. The block accepts a new operation and new operand writes on every clock, so there is no back-pressure and no handshake. The surrounding sequencer owns all ordering.

Top module: `fmac_core`

## Requirements
- R1: P equals the signed 16x16 product of the current X and Y, arithmetically shifted right by 7 bits and truncated to 24 bits. This is the top 24 bits of the Q31 fractional product.
- R2: When X and Y both hold 0x8000, P is 0x800000 (-1), not a positive value.
- R3: Reset clears X, Y, P and the accumulator and gives flags N=0, OV=0, Z=1, C=0. P changes on the same edge on which X or Y is written and holds otherwise.
- R4: op_sel 1 (load) sets the accumulator to {a_in, 8'h00}, with OV=0 and C=0. acc_hi always shows accumulator bits 23:8.
- R5: op_sel 2 (add) adds {a_in, 8'h00} to the accumulator and op_sel 3 (subtract) subtracts it. C is the carry out of bit 23 for add and the borrow (unsigned minuend less than subtrahend) for subtract.
- R6: op_sel 4 (multiply-add) and op_sel 5 (multiply-subtract) add or subtract the shifted P that was held before the edge. X or Y may be rewritten on that same edge, so a full MAC step takes one cycle.
- R7: shift_sel selects the shift applied to P for op_sel 4 and 5: 0 = none, 1 = arithmetic right 1, 2 = arithmetic right 3, 3 = left 1 (bit 23 discarded). When sh3_en is 1, the shift is arithmetic right 3 whatever shift_sel says.
- R8: OV is set when the exact signed result falls outside the 24-bit range, judged before any clamping. With sat_en=0 the stored result wraps modulo 2^24.
- R9: With sat_en=1, an overflowing result is stored as 0x7FFFFF when the exact result is positive and 0x800000 when it is negative.
- R10: N and Z reflect the stored accumulator (bit 23, all zero). op_sel 0 (hold) leaves the accumulator and all four flags unchanged.
- R11: op_sel 6 (negate) stores 0 minus the accumulator, with C set when the accumulator was non-zero. op_sel 7 (absolute) negates a negative accumulator the same way and keeps a non-negative one with C=0 and OV=0. Negating 0x800000 overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_we | input | 1 | Write strobe for X |
| x_in | input | 16 | New X operand (Q15) |
| y_we | input | 1 | Write strobe for Y |
| y_in | input | 16 | New Y operand (Q15) |
| op_sel | input | 3 | Accumulator operation code (R4, R5, R6, R10, R11) |
| a_in | input | 16 | 16-bit operand for load, add and subtract |
| shift_sel | input | 2 | Product shift select (R7) |
| sh3_en | input | 1 | Force arithmetic right-3 of the product |
| sat_en | input | 1 | Clamp on overflow when 1, wrap when 0 |
| p_out | output | 24 | Product register P (read only) |
| acc_out | output | 24 | Accumulator |
| acc_hi | output | 16 | Upper 16 bits of the accumulator |
| flag_n | output | 1 | Negative flag |
| flag_ov | output | 1 | Signed overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry/borrow flag |

## Verification
The multiplier is driven with halves, the largest positive value, the most negative value and their mixed-sign pairings. These cases separate a correct truncation point from one that is off by a bit, and they show whether 0x8000 squared wraps to -1 or is taken as positive. Accumulator sequences push sums across the positive and negative limits with saturation off and then on. This tells wrap apart from clamp and confirms that OV is judged on the exact result. Carry and borrow cases cross the unsigned boundary without a signed overflow, and a signed overflow without an unsigned carry, so C and OV cannot be swapped unnoticed. Back-to-back multiply-adds that also rewrite X each cycle show that the old P, not the new one, is accumulated. A long random run then mixes every operation, shift code and control bit.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_LOAD = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MADD = 3'd4,
    OP_MSUB = 3'd5,
    OP_NEG  = 3'd6,
    OP_ABS  = 3'd7
  } acc_op_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_R1   = 2'd1,
    SH_R3   = 2'd2,
    SH_L1   = 2'd3
  } pshift_e;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/fmac_mult.sv
// Signed fractional multiplier. Keeps the OUT_W bits just below the
// redundant sign bit of the full product. The 0x8000 * 0x8000 case lands
// on the most negative code by modular wrap.
module fmac_mult #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 24
) (
  input  logic [IN_W-1:0]  op_a,
  input  logic [IN_W-1:0]  op_b,
  output logic [OUT_W-1:0] prod
);
  localparam int FULL_W = 2 * IN_W;
  localparam int DROP   = FULL_W - 1 - OUT_W;

  logic [FULL_W-1:0] ext_a, ext_b, full;

  always_comb begin
    ext_a = {{IN_W{op_a[IN_W-1]}}, op_a};
    ext_b = {{IN_W{op_b[IN_W-1]}}, op_b};
    full  = ext_a * ext_b;
    prod  = OUT_W'(full >> DROP);
  end
endmodule

// File: rtl/fmac_shift.sv
// Product shifter between P and the arithmetic unit.
module fmac_shift
  import fmac_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] din,
  input  pshift_e      mode,
  output logic [W-1:0] dout
);
  always_comb begin
    unique case (mode)
      SH_R1:   dout = {din[W-1], din[W-1:1]};
      SH_R3:   dout = {{3{din[W-1]}}, din[W-1:3]};
      SH_L1:   dout = {din[W-2:0], 1'b0};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/fmac_alu.sv
// Accumulator arithmetic with flag generation and optional clamping.
module fmac_alu
  import fmac_pkg::*;
#(
  parameter int W = 24
) (
  input  acc_op_e      op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  logic         sat_en,
  output logic [W-1:0] res,
  output flags_t       fl
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] lhs, rhs, rhs_eff, pass_val, wrapped;
  logic [W:0]   sum;
  logic         sub, arith, ovf, cry;

  always_comb begin
    lhs      = acc;
    rhs      = opnd;
    sub      = 1'b0;
    arith    = 1'b1;
    pass_val = acc;
    unique case (op)
      OP_HOLD: arith = 1'b0;
      OP_LOAD: begin arith = 1'b0; pass_val = opnd; end
      OP_ADD, OP_MADD: sub = 1'b0;
      OP_SUB, OP_MSUB: sub = 1'b1;
      OP_NEG: begin lhs = '0; rhs = acc; sub = 1'b1; end
      OP_ABS: begin
        if (acc[W-1]) begin lhs = '0; rhs = acc; sub = 1'b1; end
        else arith = 1'b0;
      end
      default: arith = 1'b0;
    endcase

    rhs_eff = sub ? ~rhs : rhs;
    sum     = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, sub};

    if (arith) begin
      wrapped = sum[W-1:0];
      cry     = sub ? ~sum[W] : sum[W];
      ovf     = (lhs[W-1] == rhs_eff[W-1]) && (wrapped[W-1] != lhs[W-1]);
    end else begin
      wrapped = pass_val;
      cry     = 1'b0;
      ovf     = 1'b0;
    end

    if (sat_en && ovf) res = wrapped[W-1] ? MAX_POS : MAX_NEG;
    else               res = wrapped;

    fl.n  = res[W-1];
    fl.ov = ovf;
    fl.z  = (res == '0);
    fl.c  = cry;
  end
endmodule

// File: rtl/fmac_core.sv
module fmac_core
  import fmac_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             x_we,
  input  logic [IN_W-1:0]  x_in,
  input  logic             y_we,
  input  logic [IN_W-1:0]  y_in,
  input  logic [2:0]       op_sel,
  input  logic [IN_W-1:0]  a_in,
  input  logic [1:0]       shift_sel,
  input  logic             sh3_en,
  input  logic             sat_en,
  output logic [ACC_W-1:0] p_out,
  output logic [ACC_W-1:0] acc_out,
  output logic [IN_W-1:0]  acc_hi,
  output logic             flag_n,
  output logic             flag_ov,
  output logic             flag_z,
  output logic             flag_c
);
  localparam int           PAD     = ACC_W - IN_W;
  localparam logic [IN_W-1:0]  IN_MIN  = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};

  logic [IN_W-1:0]  x_q, y_q, x_nxt, y_nxt;
  logic [ACC_W-1:0] p_q, prod, p_shifted, alu_opnd, alu_res, acc_q;
  flags_t           flags_q, alu_fl;
  acc_op_e          op;
  pshift_e          smode;
  logic             is_mul_op;

  assign op        = acc_op_e'(op_sel);
  assign is_mul_op = (op == OP_MADD) || (op == OP_MSUB);
  assign smode     = sh3_en ? SH_R3 : pshift_e'(shift_sel);
  assign x_nxt     = x_we ? x_in : x_q;
  assign y_nxt     = y_we ? y_in : y_q;

  fmac_mult #(.IN_W(IN_W), .OUT_W(ACC_W)) u_mult (
    .op_a(x_nxt), .op_b(y_nxt), .prod(prod)
  );

  fmac_shift #(.W(ACC_W)) u_shift (
    .din(p_q), .mode(smode), .dout(p_shifted)
  );

  assign alu_opnd = is_mul_op ? p_shifted : {a_in, {PAD{1'b0}}};

  fmac_alu #(.W(ACC_W)) u_alu (
    .op(op), .acc(acc_q), .opnd(alu_opnd), .sat_en(sat_en),
    .res(alu_res), .fl(alu_fl)
  );

  // Operand and product registers: flow-through multiply on any write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      p_q <= '0;
    end else begin
      x_q <= x_nxt;
      y_q <= y_nxt;
      if (x_we || y_we) p_q <= prod;
    end
  end

  // Accumulator and flags.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      flags_q <= '{n: 1'b0, ov: 1'b0, z: 1'b1, c: 1'b0};
    end else if (op != OP_HOLD) begin
      acc_q   <= alu_res;
      flags_q <= alu_fl;
    end
  end

  assign p_out   = p_q;
  assign acc_out = acc_q;
  assign acc_hi  = acc_q[ACC_W-1 -: IN_W];
  assign flag_n  = flags_q.n;
  assign flag_ov = flags_q.ov;
  assign flag_z  = flags_q.z;
  assign flag_c  = flags_q.c;

  // ---- assertions ----
  p_minus_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (x_q == IN_MIN && y_q == IN_MIN) |-> (p_q == ACC_MIN));

  p_p_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_we && !y_we) |=> $stable(p_q));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (acc_q == {$past(a_in), {PAD{1'b0}}}));

  p_mac_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MADD && !sh3_en && shift_sel == 2'd0 && !sat_en)
      |=> (acc_q == $past(acc_q) + $past(p_q)));

  p_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_en && op != OP_HOLD)
      |=> (!flags_q.ov || acc_q == ACC_MAX || acc_q == ACC_MIN));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> ($stable(acc_q) && $stable(flags_q)));

  p_nz_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.z == (acc_q == '0)) && (flags_q.n == acc_q[ACC_W-1]));

endmodule

// File: tb/fmac_core_test.sv
module fmac_core_test;
  localparam logic [2:0] OP_HOLD = 3'd0, OP_LOAD = 3'd1, OP_ADD = 3'd2,
                         OP_SUB = 3'd3, OP_MADD = 3'd4, OP_MSUB = 3'd5,
                         OP_NEG = 3'd6, OP_ABS = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        x_we = 1'b0, y_we = 1'b0, sh3_en = 1'b0, sat_en = 1'b0;
  logic [15:0] x_in = '0, y_in = '0, a_in = '0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  shift_sel = '0;
  logic [23:0] p_out, acc_out;
  logic [15:0] acc_hi;
  logic        flag_n, flag_ov, flag_z, flag_c;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] mx = '0, my = '0;
  logic [23:0] mp = '0, ma = '0;
  logic        mn = 1'b0, mov = 1'b0, mz = 1'b1, mc = 1'b0;

  always #10 clk = ~clk;

  fmac_core uut (
    .clk(clk), .rst_n(rst_n), .x_we(x_we), .x_in(x_in), .y_we(y_we),
    .y_in(y_in), .op_sel(op_sel), .a_in(a_in), .shift_sel(shift_sel),
    .sh3_en(sh3_en), .sat_en(sat_en), .p_out(p_out), .acc_out(acc_out),
    .acc_hi(acc_hi), .flag_n(flag_n), .flag_ov(flag_ov), .flag_z(flag_z),
    .flag_c(flag_c)
  );

  function automatic logic [23:0] mul_ref(logic [15:0] a, logic [15:0] b);
    longint pa, pb, pr;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    pr = (pa * pb) >>> 7;
    return pr[23:0];
  endfunction

  function automatic int sx24(logic [23:0] v);
    return v[23] ? int'(v) - 16777216 : int'(v);
  endfunction

  function automatic logic [23:0] shift_ref(logic [23:0] p, int mode);
    int s;
    s = sx24(p);
    case (mode)
      1: s = s >>> 1;
      2: s = s >>> 3;
      3: s = s * 2;
      default: ;
    endcase
    return 24'(s & 24'hFFFFFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(p_out == mp, tag, "p_out", p_out, mp);
    chk(acc_out == ma, tag, "acc_out", acc_out, ma);
    chk(acc_hi == ma[23:8], tag, "acc_hi", {8'h0, acc_hi}, {8'h0, ma[23:8]});
    chk({flag_n, flag_ov, flag_z, flag_c} == {mn, mov, mz, mc}, tag,
        "flags NVZC", {20'h0, flag_n, flag_ov, flag_z, flag_c},
        {20'h0, mn, mov, mz, mc});
  endtask

  task automatic step(input logic xw, input logic [15:0] xv,
                      input logic yw, input logic [15:0] yv,
                      input logic [2:0] op, input logic [15:0] av,
                      input logic [1:0] sh, input logic s3, input logic sat,
                      input string tag);
    logic [23:0] opnd, r;
    int sa, sb, t;
    logic c, ov;
    x_we = xw; x_in = xv; y_we = yw; y_in = yv; op_sel = op; a_in = av;
    shift_sel = sh; sh3_en = s3; sat_en = sat;
    // expected values
    if (op == OP_MADD || op == OP_MSUB) opnd = shift_ref(mp, s3 ? 2 : int'(sh));
    else opnd = {av, 8'h00};
    sa = sx24(ma); sb = sx24(opnd);
    c = 1'b0; ov = 1'b0; t = sa; r = ma;
    case (op)
      OP_LOAD: begin t = sb; end
      OP_ADD, OP_MADD: begin t = sa + sb; c = (int'(ma) + int'(opnd)) >= 16777216; end
      OP_SUB, OP_MSUB: begin t = sa - sb; c = (ma < opnd); end
      OP_NEG: begin t = -sa; c = (ma != 0); end
      OP_ABS: begin
        if (sa < 0) begin t = -sa; c = 1'b1; end
        else t = sa;
      end
      default: ;
    endcase
    if (op != OP_HOLD) begin
      ov = (t > 8388607) || (t < -8388608);
      if (sat && ov) r = (t > 0) ? 24'h7FFFFF : 24'h800000;
      else r = 24'(t & 24'hFFFFFF);
      ma = r; mn = r[23]; mz = (r == 0); mov = ov; mc = c;
    end
    if (xw) mx = xv;
    if (yw) my = yv;
    if (xw || yw) mp = mul_ref(mx, my);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    compare("R3 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // products
    step(1, 16'h4000, 1, 16'h4000, OP_HOLD, 16'h0, 0, 0, 0, "R1 R3 half squared");
    step(1, 16'h8000, 1, 16'h8000, OP_HOLD, 16'h0, 0, 0, 0, "R2 min squared");
    step(1, 16'h7FFF, 1, 16'h7FFF, OP_HOLD, 16'h0, 0, 0, 0, "R1 max squared");
    step(0, 16'h0, 1, 16'h8000, OP_HOLD, 16'h0, 0, 0, 0, "R1 max times min");
    step(0, 16'h1234, 0, 16'h0, OP_HOLD, 16'h0, 0, 0, 0, "R3 P holds");

    // load, add, subtract, carry
    step(0, 0, 0, 0, OP_LOAD, 16'h1234, 0, 0, 0, "R4 load");
    step(0, 0, 0, 0, OP_ADD, 16'h7FFF, 0, 0, 0, "R8 wrap overflow");
    step(0, 0, 0, 0, OP_LOAD, 16'h7000, 0, 0, 1, "R4 load sat");
    step(0, 0, 0, 0, OP_ADD, 16'h7000, 0, 0, 1, "R9 clamp positive");
    step(0, 0, 0, 0, OP_LOAD, 16'h8000, 0, 0, 1, "R4 load min");
    step(0, 0, 0, 0, OP_SUB, 16'h0001, 0, 0, 1, "R9 clamp negative");
    step(0, 0, 0, 0, OP_LOAD, 16'hFFFF, 0, 0, 0, "R4 load -lsb");
    step(0, 0, 0, 0, OP_ADD, 16'h0001, 0, 0, 0, "R5 carry out zero");
    step(0, 0, 0, 0, OP_SUB, 16'h0001, 0, 0, 0, "R5 borrow");
    step(0, 0, 0, 0, OP_HOLD, 16'h5555, 3, 1, 1, "R10 hold");

    // one-cycle MAC
    step(1, 16'h4000, 1, 16'h4000, OP_LOAD, 16'h0000, 0, 0, 0, "R6 setup");
    step(1, 16'h2000, 0, 16'h0, OP_MADD, 16'h0, 0, 0, 0, "R6 mac old P");
    step(1, 16'hC000, 0, 16'h0, OP_MADD, 16'h0, 0, 0, 0, "R6 mac second");
    step(0, 16'h0, 0, 16'h0, OP_MSUB, 16'h0, 0, 0, 0, "R6 msub");

    // shifter codes
    for (int m = 0; m < 4; m++) begin
      step(1, 16'hA000, 1, 16'h6001, OP_LOAD, 16'h0100, 0, 0, 0, "R7 setup");
      step(0, 0, 0, 0, OP_MADD, 16'h0, 2'(m), 0, 0, "R7 shift code");
      step(0, 0, 0, 0, OP_MSUB, 16'h0, 2'(m), 1, 0, "R7 sh3 override");
    end

    // negate / absolute
    step(0, 0, 0, 0, OP_LOAD, 16'h8000, 0, 0, 0, "R11 setup");
    step(0, 0, 0, 0, OP_NEG, 16'h0, 0, 0, 0, "R11 R8 neg min wraps");
    step(0, 0, 0, 0, OP_LOAD, 16'h8000, 0, 0, 1, "R11 setup");
    step(0, 0, 0, 0, OP_NEG, 16'h0, 0, 0, 1, "R11 R9 neg min clamps");
    step(0, 0, 0, 0, OP_LOAD, 16'hF00F, 0, 0, 0, "R11 setup");
    step(0, 0, 0, 0, OP_ABS, 16'h0, 0, 0, 0, "R11 abs negative");
    step(0, 0, 0, 0, OP_ABS, 16'h0, 0, 0, 0, "R11 abs positive");
    step(0, 0, 0, 0, OP_LOAD, 16'h0000, 0, 0, 0, "R11 setup");
    step(0, 0, 0, 0, OP_NEG, 16'h0, 0, 0, 0, "R11 neg zero");

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] rx, ry;
      rx = 16'($urandom);
      ry = 16'($urandom);
      if ($urandom_range(0, 7) == 0) rx = 16'h8000;
      if ($urandom_range(0, 7) == 0) ry = ($urandom_range(0, 1) != 0) ? 16'h7FFF : 16'h8000;
      step(1'($urandom), rx, 1'($urandom), ry, 3'($urandom), 16'($urandom),
           2'($urandom), ($urandom_range(0, 3) == 0), 1'($urandom),
           "R1 R5 R6 R7 R8 R9 R10 R11 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule